// File: doc/BRIEF.md
# Serial DAC Write Port Receiver

This block is the device-side receiver for a three-wire write port that feeds a 12-bit digital-to-analog converter. A host frames each write with an active-low select line and shifts a 16-bit word in, most significant bit first, one bit per falling edge of the serial clock. When the sixteenth bit arrives, the block loads the 12-bit conversion code and a 2-bit power mode together. It raises a one-cycle strobe when they load. It also presents the power mode as a one-hot selection for the output stage.

The three serial inputs are oversampled in the block's own clock domain. They pass through a shared synchronizer, and their edges are found by comparing successive samples. A frame only counts if the select line was seen high and then low. If the select line rises before the sixteenth bit, the partial word is discarded and nothing changes. Falling serial-clock edges after the sixteenth bit in the same frame do nothing until the select line has been released. After reset the code is zero and the mode is normal operation.

Top module: `sdac_rx`

## Requirements
- R1: During and after reset, `dac_code_o` is 0, `pwr_mode_o` is 00, `mode_sel_o` is 0001 and `update_o` is 0. They stay so until the first valid frame completes.
- R2: Bits are captured MSB first, one on each falling edge of `sclk_i` while `frame_ni` is low. On the sixteenth such edge, `dac_code_o` takes word bits 11..0.
- R3: On the same load, `pwr_mode_o` takes word bits 13..12 (bit 13 is the upper mode bit). Word bits 15..14 have no effect on any output.
- R4: `mode_sel_o` is one-hot and its set bit index equals `pwr_mode_o`. Bit 0 is normal operation, bit 1 is 1 kΩ to ground, bit 2 is 100 kΩ to ground and bit 3 is output three-stated.
- R5: `update_o` is high for exactly one clock per completed frame. `dac_code_o` and `pwr_mode_o` change only in a cycle where `update_o` is high.
- R6: If `frame_ni` rises before the sixteenth falling edge, the partial word is discarded, neither output register changes and no strobe occurs. The next frame starts from an empty shift register.
- R7: Falling `sclk_i` edges after the sixteenth in a frame are ignored until `frame_ni` rises. After `frame_ni` rises and falls again, a complete new frame loads normally.
- R8: A frame starts only when `frame_ni` falls after having been seen high. Serial clock edges while `frame_ni` is high, or while it has been low since reset, load nothing.
- R9: The outputs and the strobe change on the third rising edge of `clk_i` after the sixteenth falling edge of `sclk_i` is applied. This equals SYNC_STAGES plus one with the default two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| din_i | input | 1 | Serial data, MSB first |
| dac_code_o | output | 12 | Conversion code register |
| pwr_mode_o | output | 2 | Power-mode register |
| mode_sel_o | output | 4 | One-hot decode of the power mode |
| update_o | output | 1 | One-cycle strobe when the registers load |

## Verification
Every cycle, the assertions check three things: the mode selection stays one-hot, the strobe never lasts two cycles, and the code and mode hold steady whenever the strobe is low. They also check that a strobe only follows a cycle in which the synchronized select was low. Which word gets loaded, and whether an aborted frame, a surplus clock or an unarmed start is really discarded, depends on the serial history. Only the bench's scenarios can show these. A queue-based model in the bench tracks that history and compares every output on every clock, including the exact three-cycle load latency.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int unsigned DATA_W      = 12;
  parameter int unsigned MODE_W      = 2;
  parameter int unsigned WORD_W      = 16;
  parameter int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_PD_1K    = 2'b01,
    PM_PD_100K  = 2'b10,
    PM_TRISTATE = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              din_s_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam int unsigned SH_W  = WORD_W - 1;

  logic             sclk_q;
  logic [SH_W-1:0]  shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             done_q;
  logic             sclk_fall;
  logic             take;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  // bit accepted only inside an armed, unfinished frame
  assign take      = armed_q & ~cs_s_i & ~done_q & sclk_fall;
  assign load_o    = take && (cnt_q == CNT_W'(WORD_W - 1));
  assign word_o    = {shift_q, din_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      if (cs_s_i) begin
        armed_q <= 1'b1;
        shift_q <= '0;
        cnt_q   <= '0;
        done_q  <= 1'b0;
      end else if (take) begin
        shift_q <= {shift_q[SH_W-2:0], din_s_i};
        cnt_q   <= cnt_q + 1'b1;
        if (load_o) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned MODE_W = 2,
  parameter int unsigned WORD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic [DATA_W-1:0]        dac_o,
  output logic [MODE_W-1:0]        mode_o,
  output logic [(1<<MODE_W)-1:0]   sel_o,
  output logic                     upd_o
);
  localparam int unsigned NUM_MODES = 1 << MODE_W;
  localparam int unsigned MODE_LSB  = DATA_W;

  logic [DATA_W-1:0] dac_q;
  logic [MODE_W-1:0] mode_q;
  logic              upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q  <= '0;
      mode_q <= MODE_W'(sdac_pkg::PM_NORMAL);
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        dac_q  <= word_i[DATA_W-1:0];
        mode_q <= word_i[MODE_LSB +: MODE_W];
      end
    end
  end

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_dec
    assign sel_o[m] = (mode_q == MODE_W'(m));
  end

  assign dac_o  = dac_q;
  assign mode_o = mode_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx #(
  parameter int unsigned DATA_W      = sdac_pkg::DATA_W,
  parameter int unsigned MODE_W      = sdac_pkg::MODE_W,
  parameter int unsigned WORD_W      = sdac_pkg::WORD_W,
  parameter int unsigned SYNC_STAGES = sdac_pkg::SYNC_STAGES,
  localparam int unsigned NUM_MODES  = 1 << MODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_ni,
  input  logic                 sclk_i,
  input  logic                 din_i,
  output logic [DATA_W-1:0]    dac_code_o,
  output logic [MODE_W-1:0]    pwr_mode_o,
  output logic [NUM_MODES-1:0] mode_sel_o,
  output logic                 update_o
);
  logic [2:0]        raw;
  logic [2:0]        syn;
  logic              cs_s;
  logic              load;
  logic [WORD_W-1:0] word;

  assign raw  = {frame_ni, sclk_i, din_i};
  assign cs_s = syn[2];

  // select resets as low so a frame needs a seen-high first
  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  sdac_frame #(.WORD_W(WORD_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_s_i  (cs_s),
    .sclk_s_i(syn[1]),
    .din_s_i (syn[0]),
    .load_o  (load),
    .word_o  (word)
  );

  sdac_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W), .WORD_W(WORD_W)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(word),
    .dac_o (dac_code_o),
    .mode_o(pwr_mode_o),
    .sel_o (mode_sel_o),
    .upd_o (update_o)
  );
endmodule

// File: rtl/sdac_rx_chk.sv
module sdac_rx_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned MODE_W = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cs_s_i,
  input logic [DATA_W-1:0]        dac_code_i,
  input logic [MODE_W-1:0]        pwr_mode_i,
  input logic [(1<<MODE_W)-1:0]   mode_sel_i,
  input logic                     update_i
);
  assert_mode_sel_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_sel_i) == 1);

  assert_update_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> !update_i);

  assert_hold_without_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |-> ($stable(dac_code_i) && $stable(pwr_mode_i)));

  assert_update_inside_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |-> $past(!cs_s_i));
endmodule

bind sdac_rx sdac_rx_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s_i    (cs_s),
  .dac_code_i(dac_code_o),
  .pwr_mode_i(pwr_mode_o),
  .mode_sel_i(mode_sel_o),
  .update_i  (update_o)
);

// File: tb/sdac_rx_tb_top.sv
module sdac_rx_tb_top;
  localparam int LAT  = 3;
  localparam int HALF = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b0;
  logic        sclk_i = 1'b0;
  logic        din_i = 1'b0;
  logic [11:0] dac_code_o;
  logic [1:0]  pwr_mode_o;
  logic [3:0]  mode_sel_o;
  logic        update_o;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  bit chk_en = 0;

  // reference model state
  bit   m_q[$];
  bit   m_armed = 0, m_done = 0, m_cs = 0;
  int   pend = 0;
  logic [15:0] pend_word;
  logic [11:0] exp_dac = '0;
  logic [1:0]  exp_mode = '0;
  bit          exp_upd = 0;
  int          n_frames = 0, n_upd = 0;

  always #4 clk_i = ~clk_i;

  sdac_rx dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .sclk_i    (sclk_i),
    .din_i     (din_i),
    .dac_code_o(dac_code_o),
    .pwr_mode_o(pwr_mode_o),
    .mode_sel_o(mode_sel_o),
    .update_o  (update_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    exp_upd <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        exp_dac  <= pend_word[11:0];
        exp_mode <= pend_word[13:12];
        exp_upd  <= 1'b1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (chk_en) begin
      check(dac_code_o == exp_dac, "R2", dac_code_o, exp_dac);
      check(pwr_mode_o == exp_mode, "R3", pwr_mode_o, exp_mode);
      check(mode_sel_o == 4'(1 << exp_mode), "R4", mode_sel_o, 4'(1 << exp_mode));
      check(update_o == exp_upd, "R5 R9", update_o, exp_upd);
      if (update_o) n_upd++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_cs(input bit v);
    frame_ni = v;
    m_cs = v;
    if (v) begin
      m_q.delete();
      m_done = 0;
      m_armed = 1;
    end
    wait_cyc(HALF);
  endtask

  task automatic bit_edge(input bit b);
    din_i = b;
    sclk_i = 1'b1;
    wait_cyc(HALF);
    sclk_i = 1'b0;
    if (!m_cs && m_armed && !m_done) begin
      m_q.push_back(b);
      if (m_q.size() == 16) begin
        pend_word = '0;
        foreach (m_q[k]) pend_word[15-k] = m_q[k];
        pend = LAT;
        m_done = 1;
        n_frames++;
      end
    end
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) begin
      bit_edge(w[i]);
      wait_cyc(HALF);
    end
  endtask

  task automatic frame(input logic [15:0] w);
    set_cs(1'b0);
    send_bits(w, 16);
    set_cs(1'b1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    wait_cyc(3);
    // R1: reset state while reset is held
    check(dac_code_o == 12'h000, "R1", dac_code_o, 0);
    check(pwr_mode_o == 2'b00, "R1", pwr_mode_o, 0);
    check(mode_sel_o == 4'b0001, "R1", mode_sel_o, 1);
    check(update_o == 1'b0, "R1", update_o, 0);
    rst_ni = 1'b1;
    chk_en = 1;
    wait_cyc(4);

    // R8: select low since reset, clocks must load nothing
    send_bits(16'h0FFF, 16);
    wait_cyc(6);
    check(dac_code_o == 12'h000, "R8", dac_code_o, 0);
    // R8: clocks with select high load nothing
    set_cs(1'b1);
    send_bits(16'h2AAA, 16);
    wait_cyc(6);
    check(dac_code_o == 12'h000, "R8", dac_code_o, 0);
    check(n_upd == 0, "R1", n_upd, 0);

    // R2 R3: top bits ignored
    frame(16'hC5A5);
    check(dac_code_o == 12'h5A5, "R2", dac_code_o, 12'h5A5);
    check(pwr_mode_o == 2'b00, "R3", pwr_mode_o, 0);

    // R4: each power mode
    frame(16'h1123);
    check(mode_sel_o == 4'b0010, "R4", mode_sel_o, 4'b0010);
    frame(16'h6FFF);
    check(pwr_mode_o == 2'b10 && dac_code_o == 12'hFFF, "R3", {pwr_mode_o, dac_code_o}, 14'h2FFF);
    check(mode_sel_o == 4'b0100, "R4", mode_sel_o, 4'b0100);
    frame(16'h3000);
    check(mode_sel_o == 4'b1000, "R4", mode_sel_o, 4'b1000);
    check(dac_code_o == 12'h000, "R2", dac_code_o, 0);

    // R6: abort after 15 bits and after 1 bit
    set_cs(1'b0);
    send_bits(16'h0777, 15);
    set_cs(1'b1);
    wait_cyc(4);
    check(dac_code_o == 12'h000 && pwr_mode_o == 2'b11, "R6", {pwr_mode_o, dac_code_o}, 14'h3000);
    set_cs(1'b0);
    send_bits(16'hFFFF, 1);
    set_cs(1'b1);
    frame(16'h0246);
    check(dac_code_o == 12'h246 && pwr_mode_o == 2'b00, "R6", {pwr_mode_o, dac_code_o}, 14'h0246);

    // R7: surplus clocks in the same frame
    set_cs(1'b0);
    send_bits(16'h0321, 16);
    send_bits(16'h2ABC, 16);
    wait_cyc(4);
    check(dac_code_o == 12'h321 && pwr_mode_o == 2'b00, "R7", {pwr_mode_o, dac_code_o}, 14'h0321);
    set_cs(1'b1);
    frame(16'h2ABC);
    check(dac_code_o == 12'hABC && pwr_mode_o == 2'b10, "R7", {pwr_mode_o, dac_code_o}, 14'h2ABC);

    // R9: latency from last falling edge to strobe
    set_cs(1'b0);
    send_bits(16'h1555, 15);
    bit_edge(1'b1);
    begin
      int seen = 0;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk_i);
        if (update_o && seen == 0) seen = k;
      end
      check(seen == LAT, "R9", seen, LAT);
    end
    set_cs(1'b1);
    check(dac_code_o == 12'h555 && pwr_mode_o == 2'b01, "R9", {pwr_mode_o, dac_code_o}, 14'h1555);

    wait_cyc(6);
    // R5: one strobe per completed frame
    check(n_upd == n_frames, "R5", n_upd, n_frames);
    finish_run();
  end
endmodule